// File: doc/BRIEF.md
# Byte-Wide Backplane I/O Slave

This block is the slave end of an 8-bit, processor-independent backplane bus. It watches a 12-bit I/O address space and claims a 16-byte window. The window is selected by an 8-bit base value, normally set by a switch, which is compared against address bits 11 to 4. A transfer starts only when the active-low data strobe is seen. The slave then answers with a data acknowledge, or with a transfer error when the access is refused. It holds that answer until the master removes the strobe, which completes a four-phase handshake. All bus strobes are brought into the 16 MHz system clock domain through two flip-flops.

On the local side the block drives a small register-file port. It gives a register index, write data, and one-cycle read and write strobes. It takes read data back, and a wait input that lets a slow device stretch the acknowledge by any number of clocks. Writes to registers marked read-only in a parameter mask are refused with a transfer error. While the address strobe stays low across two data-strobe pulses, the second pulse is bound to the address of the first. This keeps a read-modify-write pair indivisible.

The data lines are split into an input, an output and an output enable, for an external tristate pad.

Top module: `bpio_slave`

## Requirements
- R1: An I/O access is claimed only when addr_i[11:4] equals base_sel_i. Any other address gets no acknowledge, no error, no local strobe and no bus drive.
- R2: cmd_i is decoded as follows. Bit 2 high means a data transfer. Bit 1 low selects I/O. Bit 0 high means read and low means write. A command with bit 2 low, or with bit 1 high, is ignored entirely.
- R3: A claimed read pulses reg_rd_o for one cycle with reg_addr_o = addr_i[3:0]. It puts the register value on data_o. data_oe_o is high only while datstb_ni is low and datack_no is low.
- R4: A claimed write to a writable register pulses reg_wr_o for one cycle, carrying reg_addr_o = addr_i[3:0] and reg_wdata_o = data_i. data_oe_o stays low for the whole write.
- R5: With wait_i low, datack_no goes low at the 4th rising clock edge after datstb_ni falls. Each edge from the 4th on at which wait_i is high delays it by one clock.
- R6: A write to a register whose RO_MASK bit is set (default: registers 14 and 15) produces no reg_wr_o pulse. Instead, tfrerr_no goes low at the 3rd rising edge after datstb_ni falls. A read of such a register is acknowledged normally.
- R7: An asserted datack_no or tfrerr_no stays low while datstb_ni is low. It returns high at the 3rd rising edge after datstb_ni rises.
- R8: datack_no and tfrerr_no are never low together.
- R9: After a claimed transfer, while adrstb_ni stays low, a following data-strobe pulse goes to the first pulse's register whatever addr_i holds, including an address outside the window.
- R10: While rst_ni is low and after reset, datack_no and tfrerr_no are high, and data_oe_o, reg_rd_o and reg_wr_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, 16 MHz |
| rst_ni | input | 1 | Asynchronous reset, active low |
| base_sel_i | input | 8 | Window base, compared with addr_i[11:4] |
| addr_i | input | 12 | Bus address, I/O part |
| cmd_i | input | 3 | Command modifier code |
| adrstb_ni | input | 1 | Address strobe, active low |
| datstb_ni | input | 1 | Data strobe, active low |
| data_i | input | 8 | Bus data from the master |
| data_o | output | 8 | Read data towards the bus |
| data_oe_o | output | 1 | Bus data drive enable |
| datack_no | output | 1 | Data acknowledge, active low |
| tfrerr_no | output | 1 | Transfer error, active low |
| reg_addr_o | output | 4 | Local register index |
| reg_wdata_o | output | 8 | Local write data |
| reg_rd_o | output | 1 | Local read strobe, one cycle |
| reg_wr_o | output | 1 | Local write strobe, one cycle |
| reg_rdata_i | input | 8 | Local read data |
| wait_i | input | 1 | Local wait, stretches acknowledge |

## Verification
Take the edge at which datstb_ni falls as edge zero. The local strobe is due after the 3rd rising edge. An error is due after the 3rd edge, and an acknowledge after the 4th, plus one edge for each cycle wait_i is held. The release comes 3 edges after the strobe rises. The bench changes inputs on falling edges and counts falling edges from the strobe change. Each expected latency is pushed into the scoreboard, and the monitor checks the cycle in which the answer appeared, not only that an answer came. Refused and ignored transfers are confirmed twice: once by the write-strobe count, and once by reading the register back through the bus.

// File: rtl/bpio_pkg.sv
package bpio_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_ACK,
    ST_ERR,
    ST_SKIP
  } hs_state_e;

  typedef enum logic [1:0] {
    OP_NONE,
    OP_RD,
    OP_WR
  } op_e;

  // cmd[2]: data phase, cmd[1]: memory space, cmd[0]: read
  function automatic op_e decode_cmd(input logic [2:0] cmd);
    if (!cmd[2] || cmd[1]) return OP_NONE;
    return cmd[0] ? OP_RD : OP_WR;
  endfunction
endpackage

// File: rtl/bpio_sync.sv
module bpio_sync #(
  parameter int         W       = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic s1_q, s2_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q <= RST_VAL[b];
        s2_q <= RST_VAL[b];
      end else begin
        s1_q <= d_i[b];
        s2_q <= s1_q;
      end
    end
    assign q_o[b] = s2_q;
  end
endmodule

// File: rtl/bpio_decode.sv
module bpio_decode
  import bpio_pkg::*;
#(
  parameter int               ADDR_W  = 12,
  parameter int               REGS    = 16,
  parameter logic [REGS-1:0]  RO_MASK = '0,
  localparam int              IDX_W   = $clog2(REGS),
  localparam int              BASE_W  = ADDR_W - IDX_W
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [2:0]        cmd_i,
  input  logic [BASE_W-1:0] base_sel_i,
  input  logic              lock_i,
  input  logic [IDX_W-1:0]  lock_idx_i,
  output logic              hit_o,
  output op_e               op_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic              ro_o
);
  logic win_match;

  assign win_match = (addr_i[ADDR_W-1:IDX_W] == base_sel_i);
  assign op_o      = decode_cmd(cmd_i);
  assign idx_o     = lock_i ? lock_idx_i : addr_i[IDX_W-1:0];
  assign hit_o     = (op_o != OP_NONE) && (lock_i || win_match);
  assign ro_o      = RO_MASK[idx_o];
endmodule

// File: rtl/bpio_fsm.sv
module bpio_fsm
  import bpio_pkg::*;
#(
  parameter int  DATA_W = 8,
  parameter int  IDX_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ds_act_i,
  input  logic              as_act_i,
  input  logic              hit_i,
  input  op_e               op_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              ro_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              wait_i,
  input  logic [DATA_W-1:0] rdata_i,
  output hs_state_e         state_o,
  output logic              is_rd_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              reg_rd_o,
  output logic              reg_wr_o,
  output logic [IDX_W-1:0]  reg_addr_o,
  output logic [DATA_W-1:0] reg_wdata_o,
  output logic              lock_o,
  output logic [IDX_W-1:0]  lock_idx_o
);
  hs_state_e state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      is_rd_o     <= 1'b0;
      rdata_o     <= '0;
      reg_rd_o    <= 1'b0;
      reg_wr_o    <= 1'b0;
      reg_addr_o  <= '0;
      reg_wdata_o <= '0;
      lock_o      <= 1'b0;
      lock_idx_o  <= '0;
    end else begin
      reg_rd_o <= 1'b0;
      reg_wr_o <= 1'b0;
      if (!as_act_i) lock_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (ds_act_i) begin
            if (hit_i) begin
              reg_addr_o <= idx_i;
              if (as_act_i) begin
                lock_o     <= 1'b1;
                lock_idx_o <= idx_i;
              end
              if (op_i == OP_WR && ro_i) begin
                state_q <= ST_ERR;
              end else begin
                is_rd_o     <= (op_i == OP_RD);
                reg_rd_o    <= (op_i == OP_RD);
                reg_wr_o    <= (op_i == OP_WR);
                reg_wdata_o <= wdata_i;
                state_q     <= ST_WAIT;
              end
            end else begin
              state_q <= ST_SKIP;
            end
          end
        end
        ST_WAIT: begin
          if (!wait_i) begin
            if (is_rd_o) rdata_o <= rdata_i;
            state_q <= ST_ACK;
          end
        end
        ST_ACK, ST_ERR, ST_SKIP: begin
          if (!ds_act_i) begin
            state_q <= ST_IDLE;
            is_rd_o <= 1'b0;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign state_o = state_q;
endmodule

// File: rtl/bpio_slave.sv
module bpio_slave
  import bpio_pkg::*;
#(
  parameter int               ADDR_W  = 12,
  parameter int               DATA_W  = 8,
  parameter int               REGS    = 16,
  parameter logic [REGS-1:0]  RO_MASK = 16'hC000,
  localparam int              IDX_W   = $clog2(REGS),
  localparam int              BASE_W  = ADDR_W - IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BASE_W-1:0] base_sel_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [2:0]        cmd_i,
  input  logic              adrstb_ni,
  input  logic              datstb_ni,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o,
  output logic              datack_no,
  output logic              tfrerr_no,
  output logic [IDX_W-1:0]  reg_addr_o,
  output logic [DATA_W-1:0] reg_wdata_o,
  output logic              reg_rd_o,
  output logic              reg_wr_o,
  input  logic [DATA_W-1:0] reg_rdata_i,
  input  logic              wait_i
);
  logic [1:0]       strb_sync;
  logic             ds_act, as_act;
  logic             hit, ro, lock;
  logic [IDX_W-1:0] idx, lock_idx;
  op_e              op;
  hs_state_e        state;
  logic             is_rd;

  bpio_sync #(.W(2), .RST_VAL(2'b11)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({adrstb_ni, datstb_ni}),
    .q_o    (strb_sync)
  );
  assign ds_act = !strb_sync[0];
  assign as_act = !strb_sync[1];

  bpio_decode #(.ADDR_W(ADDR_W), .REGS(REGS), .RO_MASK(RO_MASK)) u_dec (
    .addr_i     (addr_i),
    .cmd_i      (cmd_i),
    .base_sel_i (base_sel_i),
    .lock_i     (lock),
    .lock_idx_i (lock_idx),
    .hit_o      (hit),
    .op_o       (op),
    .idx_o      (idx),
    .ro_o       (ro)
  );

  bpio_fsm #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ds_act_i    (ds_act),
    .as_act_i    (as_act),
    .hit_i       (hit),
    .op_i        (op),
    .idx_i       (idx),
    .ro_i        (ro),
    .wdata_i     (data_i),
    .wait_i      (wait_i),
    .rdata_i     (reg_rdata_i),
    .state_o     (state),
    .is_rd_o     (is_rd),
    .rdata_o     (data_o),
    .reg_rd_o    (reg_rd_o),
    .reg_wr_o    (reg_wr_o),
    .reg_addr_o  (reg_addr_o),
    .reg_wdata_o (reg_wdata_o),
    .lock_o      (lock),
    .lock_idx_o  (lock_idx)
  );

  assign datack_no = (state != ST_ACK);
  assign tfrerr_no = (state != ST_ERR);
  // raw strobe gates the drive so the bus is freed the moment the master lets go
  assign data_oe_o = (state == ST_ACK) && is_rd && !datstb_ni;
endmodule

// File: rtl/bpio_slave_chk.sv
module bpio_slave_chk #(
  parameter int              REGS    = 16,
  parameter logic [REGS-1:0] RO_MASK = '0,
  localparam int             IDX_W   = $clog2(REGS)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             datstb_ni,
  input logic             data_oe_o,
  input logic             datack_no,
  input logic             tfrerr_no,
  input logic             reg_rd_o,
  input logic             reg_wr_o,
  input logic [IDX_W-1:0] reg_addr_o
);
  a_r8_ack_err_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!datack_no && !tfrerr_no));

  a_r3_drive_qualified: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_oe_o |-> (!datstb_ni && !datack_no));

  a_r7_hold_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(datack_no) && !$past(datstb_ni, 2)) |-> !datack_no);

  a_r7_hold_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(tfrerr_no) && !$past(datstb_ni, 2)) |-> !tfrerr_no);

  a_r6_no_ro_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_wr_o |-> !RO_MASK[reg_addr_o]);

  a_r4_wr_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_wr_o |=> !reg_wr_o);

  a_r3_rd_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rd_o |=> !reg_rd_o);

  a_r10_strobe_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reg_rd_o && reg_wr_o));
endmodule

bind bpio_slave bpio_slave_chk #(.REGS(REGS), .RO_MASK(RO_MASK)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .datstb_ni  (datstb_ni),
  .data_oe_o  (data_oe_o),
  .datack_no  (datack_no),
  .tfrerr_no  (tfrerr_no),
  .reg_rd_o   (reg_rd_o),
  .reg_wr_o   (reg_wr_o),
  .reg_addr_o (reg_addr_o)
);

// File: tb/tb_bpio_slave.sv
`timescale 1ns/1ps
module tb_bpio_slave;
  localparam int CLK_PERIOD = 62;
  localparam logic [7:0] BASE = 8'h3A;

  typedef struct {
    int         kind;   // 0 none, 1 ack, 2 err
    logic [7:0] data;
    bit         oe;
    int         lat;
    string      req;
  } item_t;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  base_sel_i = BASE;
  logic [11:0] addr_i = '0;
  logic [2:0]  cmd_i = 3'b100;
  logic        adrstb_ni = 1'b1;
  logic        datstb_ni = 1'b1;
  logic [7:0]  data_i = '0;
  logic [7:0]  data_o;
  logic        data_oe_o, datack_no, tfrerr_no;
  logic [3:0]  reg_addr_o;
  logic [7:0]  reg_wdata_o;
  logic        reg_rd_o, reg_wr_o;
  logic [7:0]  reg_rdata_i;
  logic        wait_i = 1'b0;

  int n_chk = 0, n_fail = 0, wr_seen = 0;
  logic [7:0] dev_mem [16];
  logic [7:0] shadow  [16];
  item_t exp_q[$], obs_q[$];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  bpio_slave dut (.*);

  // local register file model
  assign reg_rdata_i = dev_mem[reg_addr_o];
  always @(posedge clk_i) if (reg_wr_o) begin
    dev_mem[reg_addr_o] <= reg_wdata_o;
    wr_seen <= wr_seen + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor
  initial forever begin
    wait (obs_q.size() != 0);
    begin
      item_t o, e;
      o = obs_q.pop_front();
      e = exp_q.pop_front();
      chk(o.kind == e.kind, {e.req, " response kind"}, o.kind, e.kind);
      chk(o.lat == e.lat, {e.req, " latency"}, o.lat, e.lat);
      chk(o.oe == e.oe, {e.req, " bus drive"}, int'(o.oe), int'(e.oe));
      if (e.oe) chk(o.data == e.data, {e.req, " read data"}, o.data, e.data);
    end
  end

  task automatic xfer(input logic [11:0] a, input logic [2:0] cm, input logic [7:0] d,
                      input int w, input int ek, input bit keep_as, input string req);
    item_t e, o;
    int    wr0, rel;
    bit    got;
    e.kind = ek; e.req = req; e.data = 8'h00;
    e.oe   = (ek == 1) && cm[0];
    e.lat  = (ek == 1) ? 4 + w : (ek == 2) ? 3 : 0;
    if (e.oe) e.data = shadow[a[3:0]];
    exp_q.push_back(e);
    o.kind = 0; o.lat = 0; o.oe = 1'b0; o.data = 8'h00; o.req = req;
    wr0 = wr_seen;
    @(negedge clk_i);
    addr_i = a; cmd_i = cm; data_i = d; adrstb_ni = 1'b0;
    @(negedge clk_i);
    wait_i = (w > 0); datstb_ni = 1'b0;
    got = 1'b0;
    for (int n = 1; n <= 14 && !got; n++) begin
      @(negedge clk_i);
      chk(!( !datack_no && !tfrerr_no), "R8 ack and error together", 0, 1);
      if (data_oe_o && !cm[0]) begin o.oe = 1'b1; o.data = data_o; end
      if (!datack_no) begin
        got = 1'b1; o.kind = 1; o.lat = n;
        if (data_oe_o) begin o.oe = 1'b1; o.data = data_o; end
      end else if (!tfrerr_no) begin
        got = 1'b1; o.kind = 2; o.lat = n;
      end
      if (w > 0 && n == 3 + w) wait_i = 1'b0;
    end
    wait_i = 1'b0;
    datstb_ni = 1'b1;
    #1;
    chk(!data_oe_o, {req, " R3 drive after strobe release"}, data_oe_o, 0);
    if (got) begin
      rel = 0;
      for (int n = 1; n <= 10 && rel == 0; n++) begin
        @(negedge clk_i);
        if (datack_no && tfrerr_no) rel = n;
      end
      chk(rel == 3, {req, " R7 release edge"}, rel, 3);
    end
    if (!keep_as) adrstb_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    if (ek == 1 && !cm[0]) shadow[a[3:0]] = d;
    chk(wr_seen - wr0 == ((ek == 1 && !cm[0]) ? 1 : 0), {req, " local write count"},
        wr_seen - wr0, (ek == 1 && !cm[0]) ? 1 : 0);
    obs_q.push_back(o);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) begin
      dev_mem[i] = 8'hA0 + 8'(i);
      shadow[i]  = 8'hA0 + 8'(i);
    end
    repeat (3) @(negedge clk_i);
    // R10: reset values
    chk(datack_no && tfrerr_no, "R10 handshake outputs in reset", {datack_no, tfrerr_no}, 3);
    chk(!data_oe_o && !reg_rd_o && !reg_wr_o, "R10 drive and strobes in reset",
        {data_oe_o, reg_rd_o, reg_wr_o}, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    chk(datack_no && tfrerr_no && !data_oe_o, "R10 idle after reset", {datack_no, tfrerr_no, data_oe_o}, 6);

    xfer({BASE, 4'h2}, 3'b100, 8'h55, 0, 1, 0, "R4 R5 write reg2");
    xfer({BASE, 4'h2}, 3'b101, 8'h00, 0, 1, 0, "R3 read reg2");
    xfer({BASE, 4'h0}, 3'b101, 8'h00, 3, 1, 0, "R5 read reg0 wait3");
    xfer({BASE, 4'h7}, 3'b100, 8'h3C, 2, 1, 0, "R5 R4 write reg7 wait2");
    xfer({BASE, 4'h7}, 3'b101, 8'h00, 0, 1, 0, "R4 read back reg7");
    xfer({BASE, 4'hF}, 3'b100, 8'h11, 0, 2, 0, "R6 write ro reg15");
    xfer({BASE, 4'hF}, 3'b101, 8'h00, 0, 1, 0, "R6 read ro reg15");
    xfer({BASE, 4'hE}, 3'b100, 8'h22, 4, 2, 0, "R6 write ro reg14 wait ignored");
    xfer({8'h3B, 4'h2}, 3'b100, 8'h99, 0, 0, 0, "R1 write outside window");
    xfer({8'h3B, 4'h2}, 3'b101, 8'h00, 0, 0, 0, "R1 read outside window");
    xfer({BASE, 4'h2}, 3'b101, 8'h00, 0, 1, 0, "R1 reg2 unchanged");
    xfer({BASE, 4'h4}, 3'b110, 8'h77, 0, 0, 0, "R2 memory write ignored");
    xfer({BASE, 4'h4}, 3'b000, 8'h78, 0, 0, 0, "R2 attention phase ignored");
    xfer({BASE, 4'h4}, 3'b111, 8'h00, 0, 0, 0, "R2 memory read ignored");
    xfer({BASE, 4'h4}, 3'b101, 8'h00, 0, 1, 0, "R2 reg4 unchanged");
    // R9: locked read-modify-write, second pulse addressed outside the window
    xfer({BASE, 4'h5}, 3'b101, 8'h00, 0, 1, 1, "R9 locked read reg5");
    exp_q.push_back('{kind: 1, data: 8'h00, oe: 1'b0, lat: 4, req: "R9 locked write"});
    begin
      item_t o;
      int wr0, lat;
      wr0 = wr_seen; lat = 0;
      @(negedge clk_i);
      addr_i = 12'hFF0; cmd_i = 3'b100; data_i = 8'hC3;
      @(negedge clk_i);
      datstb_ni = 1'b0;
      for (int n = 1; n <= 14 && lat == 0; n++) begin
        @(negedge clk_i);
        if (!datack_no) lat = n;
      end
      datstb_ni = 1'b1;
      adrstb_ni = 1'b1;
      repeat (5) @(negedge clk_i);
      o.kind = (lat != 0) ? 1 : 0; o.lat = lat; o.oe = 1'b0; o.data = 8'h00; o.req = "R9";
      obs_q.push_back(o);
      chk(wr_seen - wr0 == 1, "R9 locked write count", wr_seen - wr0, 1);
      shadow[5] = 8'hC3;
    end
    xfer({BASE, 4'h5}, 3'b101, 8'h00, 0, 1, 0, "R9 reg5 holds locked write");
    xfer({BASE, 4'h0}, 3'b101, 8'h00, 0, 1, 0, "R9 reg0 untouched by lock");

    repeat (5) @(negedge clk_i);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule